// File: doc/BRIEF.md
# I/Q Input Port Formatter

This block sits at the input of a dual-channel converter datapath. It takes raw sample words and turns them into aligned in-phase/quadrature pairs in one signed format, marked by a single valid strobe. It runs on the data clock, which ticks once per input word.

The block has two port arrangements. In split mode each word carries both channels at once: the I sample on port A and the Q sample on port B. In interleaved mode only port A carries data, and a channel-select line marks each word as I or Q. An I word is kept until its Q partner arrives, and then both leave together. Words may be coded as two's complement or as offset binary. Offset binary is turned into two's complement by inverting the top bit, and the result is sign-extended to the output width.

Ordering faults in interleaved mode set a sticky error flag: an I word that follows another I word, or a Q word that has no I word waiting. A change of port mode throws away any half-built pair.

Top module: `iq_port_formatter`

## Requirements
- R1: While reset is held and right after it, out_valid is 0, seq_err is 0, and out_i and out_q are all zeros.
- R2: In split mode (cfg_one_port = 0), a word presented with in_valid = 1 at a clock edge appears after that edge with out_valid = 1. out_i is the converted port_a value and out_q is the converted port_b value, so the latency is one cycle.
- R3: With cfg_offset_bin = 0, words are two's complement and are passed through. With cfg_offset_bin = 1, bit DATA_W-1 is inverted first. In both cases the DATA_W-bit result is sign-extended to OUT_W bits. The format is applied to each word in the cycle it arrives. Examples for 12 to 16 bits: offset 0x800 becomes 0x0000, offset 0xFFF becomes 0x07FF, offset 0x000 becomes 0xF800, and two's complement 0xFFF becomes 0xFFFF.
- R4: In interleaved mode (cfg_one_port = 1), chan_sel = 0 marks an I word and chan_sel = 1 marks a Q word. Data is taken from port_a only. An I word produces no output. A Q word that follows a held I word produces out_valid = 1 in the next cycle, with out_i set to the held I value and out_q set to the Q value. port_b has no effect in this mode.
- R5: In interleaved mode, an I word that arrives while an I word is already held replaces the held word and sets seq_err.
- R6: In interleaved mode, a Q word that arrives with no I word held is discarded. It produces no out_valid and sets seq_err.
- R7: seq_err stays at 1 until reset, and it is never set by traffic in split mode.
- R8: Any change of cfg_one_port discards a held I word. A later Q word is then treated as described in R6.
- R9: A cycle with in_valid = 0 gives out_valid = 0 in the next cycle, and out_i and out_q keep their last values whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock, one tick per input word |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_offset_bin | input | 1 | 0: two's complement input, 1: offset binary input |
| cfg_one_port | input | 1 | 0: split mode using both ports, 1: interleaved mode on port A |
| in_valid | input | 1 | Input word present this cycle |
| chan_sel | input | 1 | Interleaved mode channel tag: 0 for I, 1 for Q |
| port_a | input | DATA_W | I data in split mode, all data in interleaved mode |
| port_b | input | DATA_W | Q data in split mode |
| out_valid | output | 1 | Aligned pair present on out_i/out_q |
| out_i | output | OUT_W | Signed I sample |
| out_q | output | OUT_W | Signed Q sample |
| seq_err | output | 1 | Sticky interleave ordering error |

## Verification
The assertions assume that every control input is known and stable around each rising edge once reset is released. They also assume that cfg_one_port may change on any cycle, and that reset lasts at least one edge. The bench drives all inputs on the falling edge and reads outputs on the next falling edge, so each word meets exactly one rising edge. Mode changes are made only on idle cycles. This lets the flush be seen on its own, without a Q word arriving in the same cycle.

// File: rtl/iqfmt_pkg.sv
package iqfmt_pkg;

   typedef enum logic {
      CH_I = 1'b0,
      CH_Q = 1'b1
   } chan_e;

   typedef enum logic {
      FMT_TWOS   = 1'b0,
      FMT_OFFSET = 1'b1
   } fmt_e;

   typedef enum logic {
      PM_SPLIT       = 1'b0,
      PM_INTERLEAVED = 1'b1
   } pmode_e;

endpackage

// File: rtl/iqfmt_code_conv.sv
module iqfmt_code_conv #(
   parameter int DATA_W = 12,
   parameter int OUT_W  = 16
) (
   input  logic              fmt_offset,
   input  logic [DATA_W-1:0] din,
   output logic [OUT_W-1:0]  dout
);
   import iqfmt_pkg::*;

   localparam int EXT_W = OUT_W - DATA_W;

   if (DATA_W < 2) begin : g_chk_dw
      $error("iqfmt_code_conv: DATA_W must be at least 2");
   end
   if (OUT_W < DATA_W) begin : g_chk_ow
      $error("iqfmt_code_conv: OUT_W must not be below DATA_W");
   end

   logic sign_bit;
   logic [DATA_W-1:0] twos;

   // offset binary differs from two's complement only in the top bit
   always_comb begin
      sign_bit = din[DATA_W-1] ^ (fmt_offset == FMT_OFFSET);
      twos     = {sign_bit, din[DATA_W-2:0]};
   end

   if (EXT_W == 0) begin : g_same_w
      assign dout = twos;
   end else begin : g_sext
      assign dout = {{EXT_W{sign_bit}}, twos};
   end

endmodule

// File: rtl/iqfmt_pair_asm.sv
module iqfmt_pair_asm #(
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             mode_chg,
   input  logic             in_valid,
   input  logic             sel,
   input  logic [OUT_W-1:0] word,
   output logic             pair_valid,
   output logic [OUT_W-1:0] pair_i,
   output logic [OUT_W-1:0] pair_q,
   output logic             seq_fault
);
   import iqfmt_pkg::*;

   if (OUT_W < 2) begin : g_chk_w
      $error("iqfmt_pair_asm: OUT_W must be at least 2");
   end

   logic             held_q;
   logic [OUT_W-1:0] held_i_q;
   logic             held_eff;
   logic             is_i;
   logic             is_q;

   always_comb begin
      held_eff   = held_q & ~mode_chg;
      is_i       = enable & in_valid & (sel == CH_I);
      is_q       = enable & in_valid & (sel == CH_Q);
      pair_valid = is_q & held_eff;
      pair_i     = held_i_q;
      pair_q     = word;
      seq_fault  = (is_i & held_eff) | (is_q & ~held_eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q   <= 1'b0;
         held_i_q <= '0;
      end else if (is_i) begin
         held_q   <= 1'b1;
         held_i_q <= word;
      end else if (is_q || mode_chg) begin
         held_q   <= 1'b0;
      end
   end

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && !(enable && in_valid && sel == CH_I)) |=> !held_q); // R8

   AST_Q_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_valid && sel == CH_Q) |=> !held_q); // R4

endmodule

// File: rtl/iq_port_formatter.sv
module iq_port_formatter #(
   parameter int DATA_W = 12,
   parameter int OUT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_offset_bin,
   input  logic              cfg_one_port,
   input  logic              in_valid,
   input  logic              chan_sel,
   input  logic [DATA_W-1:0] port_a,
   input  logic [DATA_W-1:0] port_b,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_i,
   output logic [OUT_W-1:0]  out_q,
   output logic              seq_err
);
   import iqfmt_pkg::*;

   if (DATA_W < 2) begin : g_chk_dw
      $error("iq_port_formatter: DATA_W must be at least 2");
   end
   if (OUT_W < DATA_W) begin : g_chk_ow
      $error("iq_port_formatter: OUT_W must not be below DATA_W");
   end

   logic             mode_q;
   logic             mode_chg;
   logic [OUT_W-1:0] conv_a;
   logic [OUT_W-1:0] conv_b;
   logic             pair_valid;
   logic [OUT_W-1:0] pair_i;
   logic [OUT_W-1:0] pair_q;
   logic             seq_fault;
   logic             nxt_valid;
   logic [OUT_W-1:0] nxt_i;
   logic [OUT_W-1:0] nxt_q;

   iqfmt_code_conv #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_conv_a (
      .fmt_offset (cfg_offset_bin),
      .din        (port_a),
      .dout       (conv_a)
   );

   iqfmt_code_conv #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_conv_b (
      .fmt_offset (cfg_offset_bin),
      .din        (port_b),
      .dout       (conv_b)
   );

   iqfmt_pair_asm #(.OUT_W(OUT_W)) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (cfg_one_port),
      .mode_chg   (mode_chg),
      .in_valid   (in_valid),
      .sel        (chan_sel),
      .word       (conv_a),
      .pair_valid (pair_valid),
      .pair_i     (pair_i),
      .pair_q     (pair_q),
      .seq_fault  (seq_fault)
   );

   always_comb begin
      mode_chg = (cfg_one_port != mode_q);
      if (cfg_one_port == PM_INTERLEAVED) begin
         nxt_valid = pair_valid;
         nxt_i     = pair_i;
         nxt_q     = pair_q;
      end else begin
         nxt_valid = in_valid;
         nxt_i     = conv_a;
         nxt_q     = conv_b;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         seq_err   <= 1'b0;
      end else begin
         mode_q    <= cfg_one_port;
         out_valid <= nxt_valid;
         if (nxt_valid) begin
            out_i <= nxt_i;
            out_q <= nxt_q;
         end
         seq_err <= seq_err | seq_fault;
      end
   end

   AST_SPLIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cfg_one_port) |=> out_valid); // R2

   AST_I_WORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_one_port && chan_sel == CH_I) |=> !out_valid); // R4

   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R9

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |=> ($stable(out_i) && $stable(out_q)) || out_valid); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err); // R7

   AST_SPLIT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_one_port && !seq_err) |=> !seq_err); // R7

   AST_ORPHAN_Q: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_one_port && chan_sel == CH_Q && mode_chg) |=> (seq_err && !out_valid)); // R6

endmodule

// File: tb/sim_iq_port_formatter.sv
`timescale 1ns/1ps
module sim_iq_port_formatter;
   localparam int DW = 12;
   localparam int OW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_offset_bin = 1'b0;
   logic          cfg_one_port = 1'b0;
   logic          in_valid = 1'b0;
   logic          chan_sel = 1'b0;
   logic [DW-1:0] port_a = '0;
   logic [DW-1:0] port_b = '0;
   logic          out_valid;
   logic [OW-1:0] out_i;
   logic [OW-1:0] out_q;
   logic          seq_err;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   iq_port_formatter #(.DATA_W(DW), .OUT_W(OW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_offset_bin(cfg_offset_bin),
      .cfg_one_port(cfg_one_port), .in_valid(in_valid), .chan_sel(chan_sel),
      .port_a(port_a), .port_b(port_b), .out_valid(out_valid),
      .out_i(out_i), .out_q(out_q), .seq_err(seq_err)
   );

   function automatic logic [OW-1:0] ref_conv(input logic [DW-1:0] x, input logic offs);
      logic [DW-1:0] v;
      v = x;
      if (offs) v[DW-1] = ~v[DW-1];
      return {{(OW-DW){v[DW-1]}}, v};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive on falling edge; outputs of that word are visible at the next falling edge
   task automatic step(input logic v, input logic s, input logic [DW-1:0] a, input logic [DW-1:0] b);
      in_valid = v; chan_sel = s; port_a = a; port_b = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_reset(input logic mode);
      rst_n = 1'b0; cfg_one_port = mode; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1 out_valid", out_valid, 0);
      chk("R1 seq_err", seq_err, 0);
      chk("R1 out_i", out_i, 0);
      chk("R1 out_q", out_q, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_split();
      cfg_offset_bin = 1'b0;
      step(1, 0, 12'h123, 12'hFFF);
      chk("R2 valid", out_valid, 1);
      chk("R2 i", out_i, ref_conv(12'h123, 0));
      chk("R3 twos q neg", out_q, 32'h0000FFFF);
      step(1, 1, 12'h800, 12'h7FF);
      chk("R2 i second", out_i, 32'h0000F800);
      chk("R2 q second", out_q, 32'h000007FF);
      cfg_offset_bin = 1'b1;
      step(1, 0, 12'h800, 12'hFFF);
      chk("R3 offset mid", out_i, 32'h00000000);
      chk("R3 offset top", out_q, 32'h000007FF);
      step(1, 0, 12'h000, 12'h801);
      chk("R3 offset bottom", out_i, 32'h0000F800);
      chk("R3 offset q", out_q, ref_conv(12'h801, 1));
      cfg_offset_bin = 1'b0;
      chk("R7 no err split", seq_err, 0);
   endtask

   task automatic t_idle();
      step(1, 0, 12'h055, 12'h0AA);
      step(0, 0, 12'h3C3, 12'h111);
      chk("R9 idle valid", out_valid, 0);
      chk("R9 hold i", out_i, 32'h00000055);
      chk("R9 hold q", out_q, 32'h000000AA);
   endtask

   task automatic t_one_port();
      do_reset(1'b1);
      step(1, 0, 12'h123, 12'h7FF);
      chk("R4 I silent", out_valid, 0);
      step(1, 1, 12'h456, 12'h7FF);
      chk("R4 pair valid", out_valid, 1);
      chk("R4 pair i", out_i, 32'h00000123);
      chk("R4 pair q from port_a", out_q, 32'h00000456);
      cfg_offset_bin = 1'b1;
      step(1, 0, 12'hFFF, 12'h000);
      step(1, 1, 12'h000, 12'h000);
      chk("R3 one-port i", out_i, 32'h000007FF);
      chk("R3 one-port q", out_q, 32'h0000F800);
      cfg_offset_bin = 1'b0;
      chk("R4 no err", seq_err, 0);
   endtask

   task automatic t_double_i();
      do_reset(1'b1);
      step(1, 0, 12'h111, 12'h0);
      step(1, 0, 12'h222, 12'h0);
      chk("R5 err set", seq_err, 1);
      chk("R5 no out", out_valid, 0);
      step(1, 1, 12'h333, 12'h0);
      chk("R5 pair valid", out_valid, 1);
      chk("R5 later I kept", out_i, 32'h00000222);
      chk("R5 q", out_q, 32'h00000333);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      chk("R7 sticky", seq_err, 1);
      do_reset(1'b0);
      chk("R7 cleared by reset", seq_err, 0);
   endtask

   task automatic t_orphan_q();
      do_reset(1'b1);
      step(1, 1, 12'h321, 12'h0);
      chk("R6 no out", out_valid, 0);
      chk("R6 err", seq_err, 1);
   endtask

   task automatic t_flush();
      do_reset(1'b1);
      step(1, 0, 12'h0AB, 12'h0);
      cfg_one_port = 1'b0;
      step(0, 0, 0, 0);
      cfg_one_port = 1'b1;
      step(0, 0, 0, 0);
      chk("R8 no err yet", seq_err, 0);
      step(1, 1, 12'h0CD, 12'h0);
      chk("R8 flushed no out", out_valid, 0);
      chk("R8 flushed err", seq_err, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      t_reset();
      t_split();
      t_idle();
      t_one_port();
      t_double_i();
      t_orphan_q();
      t_flush();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule